// File: doc/BRIEF.md
# Channel Address Sequencer

This block is the digital control core of a multiplexed data-acquisition front end. A falling edge on an active-low strobe input chooses the analog channel for the next sample and starts one measurement cycle. The channel comes from one of three sources, decided by two mode inputs when the edge is taken. A low clear input forces channel 0. Otherwise a low load input takes a channel number from the address inputs. With both inputs high, the channel register steps up by one.

Each cycle has two phases. An acquisition phase lets the multiplexer and amplifier settle, and its length is a programmable number of clock cycles, so high-gain settings can be given more time. A conversion phase of fixed length follows. The end-of-conversion flag is low while the block is idle or acquiring and high while it converts. Its falling edge means the result is ready.

If that flag is wired back into the strobe, the block scans the channels on its own, moving to the next channel each time a conversion completes. A one-hot channel select, gated by a mux-enable input, drives the analog switches.

Top module: `acq_seq_ctrl`

## Requirements
- R1: With clear_n high and load_n low, an accepted strobe edge stores addr_in into chan_addr.
- R2: With clear_n and load_n both high, an accepted strobe edge adds one to chan_addr, wrapping from the last channel to 0, and addr_in has no effect.
- R3: With clear_n low, an accepted strobe edge sets chan_addr to 0, whatever load_n and addr_in are.
- R4: When mux_en_in is high, chan_sel has exactly bit number chan_addr set. When mux_en_in is low, chan_sel is all zero. mux_en_out always equals mux_en_in.
- R5: chan_addr changes SYNC_STAGES+1 clock edges after the first edge that samples strobe_n low. Counting from that change, eoc stays low for acq_cycles cycles, where a value of 0 acts as 1. eoc is then high for CONV_CYCLES cycles and falls back to low. sample_hold is high exactly while eoc is high. start_conv pulses high for one cycle, in the first cycle that eoc is high.
- R6: A strobe falling edge taken while a cycle is running is dropped: it does not change chan_addr or eoc timing, and it does not start a further cycle.
- R7: With eoc connected to strobe_n, the block repeats cycles back to back every SYNC_STAGES+acq_cycles+CONV_CYCLES+1 clock cycles, and each cycle advances the channel as in R2.
- R8: While rst_n is low at a clock edge (synchronous, active low), the block returns to idle with chan_addr 0 and eoc, sample_hold and start_conv low, even when a cycle is running.
- R9: With CH_COUNT set to 8, chan_addr is 3 bits wide and stepping wraps from 7 to 0.
- R10: acq_cycles is captured when the edge is accepted. Changing it later in the cycle does not change the cycle's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Cycle start; a falling edge is the trigger; may be asynchronous |
| load_n | input | 1 | Low selects taking the channel from addr_in |
| clear_n | input | 1 | Low forces channel 0 on the next accepted edge |
| addr_in | input | ADDR_W | Channel number for random selection |
| mux_en_in | input | 1 | Enables the channel select outputs |
| acq_cycles | input | ACQ_W | Acquisition length in clock cycles |
| chan_addr | output | ADDR_W | Registered channel number, straight binary |
| chan_sel | output | CH_COUNT | One-hot analog switch select |
| mux_en_out | output | 1 | Copy of mux_en_in |
| sample_hold | output | 1 | High means hold, during conversion |
| start_conv | output | 1 | One-cycle pulse that starts the converter |
| eoc | output | 1 | Low while idle or acquiring, high while converting |

## Verification
The hardest case to reach from the ports is a strobe edge that arrives in the middle of an acquisition, at the same time as new mode inputs, a new address and a new acquisition length. The stimulus lowers the strobe long enough to pass the synchronizer while the block is acquiring. It then checks that eoc timing and the final channel match the cycle already in progress. Free-running operation is exercised by feeding eoc back into the strobe for more than one full wrap of both the 16-channel and the 8-channel instance. Each back-to-back cycle is checked with the same cycle-by-cycle timeline as a driven strobe.

// File: rtl/acq_seq_pkg.sv
// Shared types for the channel address sequencer.
// Assumes: nothing beyond a synthesizable SystemVerilog flow.
package acq_seq_pkg;

    // Measurement cycle phase
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACQ  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    // Where the next channel number comes from
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_ZERO   = 2'd1,
        SRC_RANDOM = 2'd2,
        SRC_STEP   = 2'd3
    } addr_src_e;

endpackage

// File: rtl/acq_strobe_edge.sv
// Strobe falling-edge detector.
// Brings the active-low strobe through SYNC_STAGES flops (none when the
// parameter is 0, for a strobe that is already synchronous), then
// flags a high-to-low change for one cycle.
// Assumes: the strobe stays low for at least SYNC_STAGES+1 clock cycles.
module acq_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall_o
);

    logic synced;
    logic prev_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;

            // Shift the raw strobe through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q[0] <= strobe_n;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        chain_q[i] <= chain_q[i-1];
                    end
                end
            end

            assign synced = chain_q[SYNC_STAGES-1];
        end else begin : g_direct
            assign synced = strobe_n;
        end
    endgenerate

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= synced;
        end
    end

    assign fall_o = prev_q & ~synced;

endmodule

// File: rtl/acq_phase_timer.sv
// Acquisition and conversion phase timer.
// Takes an edge only when idle (the commit). On a commit it loads the
// acquisition length and counts it down, then counts CONV_CYCLES of
// conversion and returns to idle. One counter serves both phases.
// Assumes: CONV_CYCLES >= 1; an acquisition length of 0 counts as 1.
module acq_phase_timer
    import acq_seq_pkg::*;
#(
    parameter int ACQ_W       = 16,
    parameter int CONV_CYCLES = 450
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [ACQ_W-1:0] acq_cycles,
    output logic             commit_o,
    output phase_e           phase_o,
    output logic             start_conv_o
);

    localparam int CONV_W = $clog2(CONV_CYCLES + 1);
    localparam int CNT_W  = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;
    localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             start_q;

    // An edge counts only when no cycle is running
    assign commit_o = fall_i && (phase_q == PH_IDLE);

    // Phase sequencing and shared down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (commit_o) begin
                        phase_q <= PH_ACQ;
                        cnt_q   <= (acq_cycles == '0) ? '0
                                   : CNT_W'(acq_cycles) - 1'b1;
                    end
                end
                PH_ACQ: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_CONV;
                        cnt_q   <= CONV_LAST;
                        start_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o      = phase_q;
    assign start_conv_o = start_q;

endmodule

// File: rtl/acq_addr_reg.sv
// Channel address register with mode decode.
// On a commit: clear_n low forces 0 first. Otherwise load_n low takes
// addr_in. Otherwise the register steps up by one, wrapping after
// channel CH_COUNT-1. Between commits it holds.
// Assumes: the mode inputs and addr_in are stable around the commit.
module acq_addr_reg
    import acq_seq_pkg::*;
#(
    parameter int CH_COUNT = 16,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic              clear_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CH_COUNT - 1);

    addr_src_e         src;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] next_addr;

    // Priority decode of the address source
    always_comb begin
        src = SRC_HOLD;
        if (commit_i) begin
            if (!clear_n) begin
                src = SRC_ZERO;
            end else if (!load_n) begin
                src = SRC_RANDOM;
            end else begin
                src = SRC_STEP;
            end
        end
    end

    // Next sequential channel with wrap at the last channel
    assign step_addr = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

    // Select the next register value
    always_comb begin
        case (src)
            SRC_ZERO:   next_addr = '0;
            SRC_RANDOM: next_addr = addr_in;
            SRC_STEP:   next_addr = step_addr;
            default:    next_addr = addr_q;
        endcase
    end

    // Channel register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= next_addr;
        end
    end

endmodule

// File: rtl/acq_chan_decode.sv
// One-hot channel select decoder, gated by the mux enable.
// Assumes: nothing; channel numbers beyond CH_COUNT-1 select nothing.
module acq_chan_decode #(
    parameter int CH_COUNT = 16,
    parameter int ADDR_W   = 4
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                en_i,
    output logic [CH_COUNT-1:0] sel_o
);

    generate
        for (genvar g = 0; g < CH_COUNT; g++) begin : g_sel
            // One select line per analog channel
            assign sel_o[g] = en_i && (addr_i == ADDR_W'(g));
        end
    endgenerate

endmodule

// File: rtl/acq_seq_ctrl.sv
// Channel address sequencer, top level.
// A falling strobe, once synchronized, picks the channel (clear, random
// or step) and starts one acquisition plus conversion cycle. eoc is high
// only during conversion. Feeding eoc back to strobe_n makes it scan
// the channels on its own.
// Assumes: CH_COUNT >= 2, CONV_CYCLES >= 1, strobe_n low for longer than
// SYNC_STAGES+1 cycles.
module acq_seq_ctrl
    import acq_seq_pkg::*;
#(
    parameter int CH_COUNT    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ACQ_W       = 16,
    parameter int CONV_CYCLES = 450,
    localparam int ADDR_W     = $clog2(CH_COUNT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strobe_n,
    input  logic                load_n,
    input  logic                clear_n,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic                mux_en_in,
    input  logic [ACQ_W-1:0]    acq_cycles,
    output logic [ADDR_W-1:0]   chan_addr,
    output logic [CH_COUNT-1:0] chan_sel,
    output logic                mux_en_out,
    output logic                sample_hold,
    output logic                start_conv,
    output logic                eoc
);

    logic   fall_w;
    logic   commit_w;
    phase_e phase_w;

    acq_strobe_edge #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe_n(strobe_n),
        .fall_o  (fall_w)
    );

    acq_phase_timer #(
        .ACQ_W      (ACQ_W),
        .CONV_CYCLES(CONV_CYCLES)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_i      (fall_w),
        .acq_cycles  (acq_cycles),
        .commit_o    (commit_w),
        .phase_o     (phase_w),
        .start_conv_o(start_conv)
    );

    acq_addr_reg #(
        .CH_COUNT(CH_COUNT),
        .ADDR_W  (ADDR_W)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit_i(commit_w),
        .clear_n (clear_n),
        .load_n  (load_n),
        .addr_in (addr_in),
        .addr_q  (chan_addr)
    );

    acq_chan_decode #(
        .CH_COUNT(CH_COUNT),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .addr_i(chan_addr),
        .en_i  (mux_en_in),
        .sel_o (chan_sel)
    );

    assign mux_en_out  = mux_en_in;
    assign eoc         = (phase_w == PH_CONV);
    assign sample_hold = (phase_w == PH_CONV);

endmodule

// File: rtl/acq_seq_ctrl_chk.sv
// Property checker for acq_seq_ctrl, attached by the bind below.
// Assumes: it observes the top's ports and the internal commit strobe.
module acq_seq_ctrl_chk #(
    parameter int CH_COUNT = 16,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                commit,
    input logic                clear_n,
    input logic                load_n,
    input logic [ADDR_W-1:0]   addr_in,
    input logic                mux_en_in,
    input logic [ADDR_W-1:0]   chan_addr,
    input logic [CH_COUNT-1:0] chan_sel,
    input logic                start_conv,
    input logic                eoc
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(CH_COUNT - 1);

    a_r3_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !clear_n) |=> (chan_addr == '0));

    a_r1_random_load: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && clear_n && !load_n) |=> (chan_addr == $past(addr_in)));

    a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && clear_n && load_n) |=>
        (chan_addr == (($past(chan_addr) == LAST_ADDR) ? '0 : $past(chan_addr) + 1'b1)));

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(chan_addr));

    a_r6_commit_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !eoc);

    a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel));

    a_r4_sel_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_en_in |-> (chan_sel == '0));

    a_r4_sel_index: assert property (@(posedge clk) disable iff (!rst_n)
        mux_en_in |-> chan_sel[chan_addr]);

    a_r5_start_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
        start_conv |-> eoc);

    a_r5_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> start_conv);

    a_r5_acq_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !eoc);

endmodule

bind acq_seq_ctrl acq_seq_ctrl_chk #(
    .CH_COUNT(CH_COUNT),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_w),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .addr_in   (addr_in),
    .mux_en_in (mux_en_in),
    .chan_addr (chan_addr),
    .chan_sel  (chan_sel),
    .start_conv(start_conv),
    .eoc       (eoc)
);

// File: tb/acq_seq_ctrl_tb_top.sv
// Self-checking bench: a 16-channel and an 8-channel instance share
// their stimulus, and expected values come from an arithmetic model.
module acq_seq_ctrl_tb_top;

    localparam int SYNC = 2;
    localparam int CONV = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_drv;
    logic        free_run;
    logic        strobe_n;
    logic        load_n;
    logic        clear_n;
    logic [3:0]  addr_in;
    logic        mux_en;
    logic [7:0]  acq_cycles;

    logic [3:0]  addr16;
    logic [15:0] sel16;
    logic        men16, sh16, sc16, eoc16;
    logic [2:0]  addr8;
    logic [7:0]  sel8;
    logic        men8, sh8, sc8, eoc8;

    int n_checks = 0;
    int n_err    = 0;
    int exp_addr = 0;

    always #10 clk = ~clk;

    assign strobe_n = free_run ? eoc16 : strobe_drv;

    acq_seq_ctrl #(.CH_COUNT(16), .SYNC_STAGES(SYNC), .ACQ_W(8), .CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .load_n(load_n), .clear_n(clear_n),
        .addr_in(addr_in), .mux_en_in(mux_en), .acq_cycles(acq_cycles),
        .chan_addr(addr16), .chan_sel(sel16), .mux_en_out(men16),
        .sample_hold(sh16), .start_conv(sc16), .eoc(eoc16));

    acq_seq_ctrl #(.CH_COUNT(8), .SYNC_STAGES(SYNC), .ACQ_W(8), .CONV_CYCLES(CONV)) dut8_i (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .load_n(load_n), .clear_n(clear_n),
        .addr_in(addr_in[2:0]), .mux_en_in(mux_en), .acq_cycles(acq_cycles),
        .chan_addr(addr8), .chan_sel(sel8), .mux_en_out(men8),
        .sample_hold(sh8), .start_conv(sc8), .eoc(eoc8));

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    // Address and select outputs of both instances against the model
    task automatic chk_addr(input string req);
        int e8;
        int s16;
        int s8;
        e8  = exp_addr % 8;
        s16 = mux_en ? (1 << exp_addr) : 0;
        s8  = mux_en ? (1 << e8) : 0;
        chk(int'(addr16) == exp_addr, req, "chan_addr", int'(addr16), exp_addr);
        chk(int'(sel16) == s16, "R4", "chan_sel", int'(sel16), s16);
        chk(men16 == mux_en, "R4", "mux_en_out", int'(men16), int'(mux_en));
        chk(int'(addr8) == e8, "R9", "chan_addr 8ch", int'(addr8), e8);
        chk(int'(sel8) == s8, "R9", "chan_sel 8ch", int'(sel8), s8);
    endtask

    // One measurement cycle, entered and left at a falling clock edge
    task automatic run_cycle(input bit drive, input int acq, input string req,
                             input bit disturb);
        int eff;
        int nxt;
        bit exp_eoc;
        bit exp_sc;
        eff = (acq == 0) ? 1 : acq;
        acq_cycles = 8'(acq);
        if (!clear_n) nxt = 0;
        else if (!load_n) nxt = int'(addr_in);
        else nxt = (exp_addr + 1) % 16;
        if (drive) strobe_drv = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        chk(int'(addr16) == exp_addr, "R5", "addr before commit", int'(addr16), exp_addr);
        @(negedge clk);
        exp_addr = nxt;
        chk_addr(req);
        chk(eoc16 == 1'b0, "R5", "eoc at commit", int'(eoc16), 0);
        if (drive) strobe_drv = 1'b1;
        for (int t = 1; t <= eff + CONV; t++) begin
            @(negedge clk);
            if (disturb && t == 1) begin
                strobe_drv = 1'b0;
                load_n     = 1'b0;
                addr_in    = 4'(exp_addr ^ 5);
                acq_cycles = 8'd1;
            end
            if (disturb && t == 4) strobe_drv = 1'b1;
            exp_eoc = (t >= eff) && (t < eff + CONV);
            exp_sc  = (t == eff);
            chk(eoc16 == exp_eoc, disturb ? "R10" : "R5", "eoc", int'(eoc16), int'(exp_eoc));
            chk(sh16 == exp_eoc, "R5", "sample_hold", int'(sh16), int'(exp_eoc));
            chk(sc16 == exp_sc, "R5", "start_conv", int'(sc16), int'(exp_sc));
            chk(eoc8 == exp_eoc, "R9", "eoc 8ch", int'(eoc8), int'(exp_eoc));
        end
        chk_addr(disturb ? "R6" : req);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R5 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        strobe_drv = 1'b1;
        free_run   = 1'b0;
        load_n     = 1'b1;
        clear_n    = 1'b1;
        addr_in    = 4'd0;
        mux_en     = 1'b1;
        acq_cycles = 8'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: state after reset
        exp_addr = 0;
        chk_addr("R8");
        chk(eoc16 == 1'b0, "R8", "eoc", int'(eoc16), 0);
        chk(sh16 == 1'b0, "R8", "sample_hold", int'(sh16), 0);
        chk(sc16 == 1'b0, "R8", "start_conv", int'(sc16), 0);

        // R1: random selection over every channel, mux enable toggling (R4)
        load_n = 1'b0;
        for (int i = 0; i < 16; i++) begin
            addr_in = 4'((i * 11 + 3) % 16);
            mux_en  = (i % 3) != 0;
            run_cycle(1'b1, i % 4, "R1", 1'b0);
        end
        mux_en = 1'b1;

        // R3: clear wins over random and over stepping
        clear_n = 1'b0;
        addr_in = 4'd9;
        run_cycle(1'b1, 2, "R3", 1'b0);
        clear_n = 1'b1;
        addr_in = 4'd12;
        run_cycle(1'b1, 1, "R1", 1'b0);
        clear_n = 1'b0;
        load_n  = 1'b1;
        addr_in = 4'd6;
        run_cycle(1'b1, 3, "R3", 1'b0);

        // R2: stepping through both wraps, addr_in changing and ignored
        clear_n = 1'b1;
        load_n  = 1'b0;
        addr_in = 4'd13;
        run_cycle(1'b1, 1, "R1", 1'b0);
        load_n = 1'b1;
        for (int k = 0; k < 18; k++) begin
            addr_in = 4'((k * 5) % 16);
            run_cycle(1'b1, 1 + k % 3, "R2", 1'b0);
        end

        // R6 and R10: strobe, new mode, address and length during acquisition
        run_cycle(1'b1, 8, "R2", 1'b1);
        load_n = 1'b1;
        for (int w = 0; w < 12; w++) begin
            @(negedge clk);
            chk(eoc16 == 1'b0, "R6", "no extra cycle", int'(eoc16), 0);
        end
        chk_addr("R6");

        // R7: eoc fed back to strobe, free-running scan
        free_run = 1'b1;
        for (int k = 0; k < 18; k++) begin
            run_cycle(1'b0, 3, "R7", 1'b0);
        end
        free_run = 1'b0;
        for (int w = 0; w < 10; w++) begin
            @(negedge clk);
            chk(eoc16 == 1'b0, "R7", "stopped", int'(eoc16), 0);
        end
        chk_addr("R7");

        // R8: reset in the middle of a cycle
        load_n     = 1'b0;
        addr_in    = 4'd7;
        acq_cycles = 8'd6;
        strobe_drv = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        chk(int'(addr16) == 7, "R8", "loaded before reset", int'(addr16), 7);
        rst_n      = 1'b0;
        strobe_drv = 1'b1;
        repeat (2) @(negedge clk);
        rst_n    = 1'b1;
        exp_addr = 0;
        for (int w = 0; w < 15; w++) begin
            @(negedge clk);
            chk(eoc16 == 1'b0 && sc16 == 1'b0, "R8", "idle after reset", int'(eoc16), 0);
        end
        chk_addr("R8");

        summary();
        $finish;
    end

endmodule